// File: doc/BRIEF.md
# Secondary core power-up sequencer

This block wakes one of two secondary processor cores from power-down on its own, with no software stepping through the power registers. A one-cycle start request carries a core index. The sequencer then owns a simple register master port (address, write data, read and write strobes, read data, acknowledge and error) into the power-management block. It first reads the global control word to see whether the core is already out of reset. If the core is still held, it walks the core's logic and memory power steps in a fixed order, waiting on status fields between steps, and finally releases the core's reset.

Every write into the per-core power register is built from the last value read from it, so command bits set by earlier steps are kept. Steps that wait on hardware write once and then keep reading the same register until the status field comes up. Each wait is bounded by a programmable cycle limit. Only one sequence runs at a time, so two requests can never interleave on the power registers. The sequencer reports busy, and ends each request with exactly one of three single-cycle pulses: done, already-on or error.

Top module: `core_wake_seq`

## Requirements
- R1: All traffic goes to the control word at address 0x30 or to the selected core's power register at 0x34 + 4*n. Core 1 uses 0x38. Nothing else is ever addressed.
- R2: The first transaction is a read of 0x30. If bit 13+n of that value is 1, the request ends with an alreadyOn pulse and nothing is written. The other core's bit has no effect.
- R3: Logic power-on: the core register is read, then written with bits [21:20] set. It is then re-read until bits [29:28] both read 1.
- R4: Logic power-good: bits [17:16] are also set in the next write. The register is then re-read until bits [25:24] both read 1.
- R5: Two plain writes follow, with no reads after either. The first clears bit 15 (logic clamp). The second clears bits [11:8] (memory power-down array field).
- R6: Memory steps: set bit 1 and re-read until bit 5 is 1. Then set bit 0 and re-read until bit 4 is 1. Then clear bit 2 (memory clamp) with a plain write.
- R7: The last transaction writes 0x30 with the value read at the start plus bit 13+n set. A donePulse follows its acknowledge.
- R8: Each step writes exactly once. A polled step then reads only the same register, and stops on the first read whose field matches. Each write keeps the command bits of all earlier steps.
- R9: Only one of busRd and busWr is high at a time. A raised strobe stays high, with stable address and write data, until busAck.
- R10: A transaction acknowledged with busErr ends the request with errPulse, and no further transaction follows.
- R11: A poll read that does not match the field is fatal when at least pollLimit cycles have passed in that wait. It ends the request with errPulse. A matching read always proceeds, even with pollLimit at 0.
- R12: A start while busy is ignored. A core index above 1 gets an errPulse in the next cycle, with no bus traffic and without raising busy.
- R13: After reset, busy, the strobes and the pulses are low. busy rises the cycle after an accepted start and falls with the end pulse. The done, alreadyOn and errPulse pulses last one cycle, and only one of them is ever high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle request to wake a core |
| coreSel | input | SEL_W | Index of the core to wake, sampled with startReq |
| pollLimit | input | TIMER_W | Cycle bound for each status wait |
| busAddr | output | ADDR_W | Register address of the current transaction |
| busWdata | output | 32 | Write data of the current transaction |
| busRd | output | 1 | Read request, held until busAck |
| busWr | output | 1 | Write request, held until busAck |
| busRdata | input | 32 | Read data, valid with busAck |
| busAck | input | 1 | Transaction complete |
| busErr | input | 1 | Transaction failed, valid with busAck |
| busy | output | 1 | A request is in progress |
| donePulse | output | 1 | Core reset released |
| alreadyOn | output | 1 | Core was already out of reset |
| errPulse | output | 1 | Bad index, bus error or wait timeout |

## Verification
The bench models the power block. Its status fields follow the written command bits after a chosen number of reads, and it can be made to stick, to return an error on a chosen transaction, and to acknowledge after a random delay. It records every transaction and compares the writes with the cumulative command values. This catches a design that drops an earlier step's bits, reorders steps or polls after a plain write. It also catches one that writes the stale control word, or whose waits run longer than the status lag allows.

Directed cases cover the rest:
- An already-on core whose sibling's bit is set, and the reverse. A wrong bit index would skip the wake-up or wake the wrong core.
- An error on the very first read and on the final write. A design that ignores busErr would still release the reset.
- A stuck status with a small limit, and a zero limit with an immediately matching status. One misses the timeout; the other aborts too eagerly.
- A second start during a run, and out-of-range indices. Either could start traffic for another core.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

  localparam int REG_W        = 32;
  localparam int STEP_W       = 3;
  localparam int LAST_STEP    = 7;
  localparam int RST_BIT_BASE = 13;

  localparam logic [REG_W-1:0] LOGIC_ON_CMD  = 32'h0030_0000;
  localparam logic [REG_W-1:0] LOGIC_OK_CMD  = 32'h0003_0000;
  localparam logic [REG_W-1:0] LOGIC_CLAMP   = 32'h0000_8000;
  localparam logic [REG_W-1:0] MEM_ARRAY_PD  = 32'h0000_0F00;
  localparam logic [REG_W-1:0] MEM_ON_CMD    = 32'h0000_0002;
  localparam logic [REG_W-1:0] MEM_OK_CMD    = 32'h0000_0001;
  localparam logic [REG_W-1:0] MEM_CLAMP     = 32'h0000_0004;
  localparam logic [REG_W-1:0] LOGIC_ON_STAT = 32'h3000_0000;
  localparam logic [REG_W-1:0] LOGIC_OK_STAT = 32'h0300_0000;
  localparam logic [REG_W-1:0] MEM_ON_STAT   = 32'h0000_0020;
  localparam logic [REG_W-1:0] MEM_OK_STAT   = 32'h0000_0010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTRL,
    ST_RD_PWR,
    ST_WR,
    ST_POLL
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchCore;
    logic latchCtrl;
    logic loadRead;
    logic loadWrite;
    logic timerClr;
    logic timerRun;
    logic selCtrl;
  } dpCtrl_t;

  // Order of the steps is behaviour: index 7 is the reset release.
  function automatic logic [REG_W-1:0] stepSetBits(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(0): return LOGIC_ON_CMD;
      STEP_W'(1): return LOGIC_OK_CMD;
      STEP_W'(4): return MEM_ON_CMD;
      STEP_W'(5): return MEM_OK_CMD;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] stepClrBits(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(2): return LOGIC_CLAMP;
      STEP_W'(3): return MEM_ARRAY_PD;
      STEP_W'(6): return MEM_CLAMP;
      default:    return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] stepPollBits(input logic [STEP_W-1:0] s);
    case (s)
      STEP_W'(0): return LOGIC_ON_STAT;
      STEP_W'(1): return LOGIC_OK_STAT;
      STEP_W'(4): return MEM_ON_STAT;
      STEP_W'(5): return MEM_OK_STAT;
      default:    return '0;
    endcase
  endfunction

  function automatic logic stepPolls(input logic [STEP_W-1:0] s);
    return stepPollBits(s) != '0;
  endfunction

endpackage

// File: rtl/core_wake_dp.sv
module core_wake_dp
  import core_wake_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TIMER_W     = 16,
  parameter int CTRL_OFFSET = 'h30,
  parameter int PWR_BASE    = 'h34,
  parameter int PWR_STRIDE  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            cmd,
  input  logic [STEP_W-1:0]  stepIdx,
  input  logic               coreIn,
  input  logic [REG_W-1:0]   rdata,
  input  logic [TIMER_W-1:0] pollLimit,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [REG_W-1:0]   busWdata,
  output logic               pollMet,
  output logic               coreIsOn,
  output logic               timedOut
);

  logic               coreReg;
  logic [REG_W-1:0]   ctrlSave;
  logic [REG_W-1:0]   valReg;
  logic [TIMER_W-1:0] timer;
  logic [REG_W-1:0]   rstMask;
  logic [REG_W-1:0]   stepVal;
  logic [REG_W-1:0]   pollBits;
  logic [ADDR_W-1:0]  pwrAddr;

  always_comb begin
    rstMask = '0;
    rstMask[RST_BIT_BASE + int'(coreReg)] = 1'b1;
  end

  assign pollBits = stepPollBits(stepIdx);
  assign stepVal  = (stepIdx == STEP_W'(LAST_STEP))
                  ? (ctrlSave | rstMask)
                  : ((valReg | stepSetBits(stepIdx)) & ~stepClrBits(stepIdx));
  assign pwrAddr  = ADDR_W'(PWR_BASE) + (coreReg ? ADDR_W'(PWR_STRIDE) : ADDR_W'(0));

  assign busAddr  = cmd.selCtrl ? ADDR_W'(CTRL_OFFSET) : pwrAddr;
  assign busWdata = stepVal;
  assign pollMet  = (rdata & pollBits) == pollBits;
  assign coreIsOn = (rdata & rstMask) != '0;
  assign timedOut = timer >= pollLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreReg  <= 1'b0;
      ctrlSave <= '0;
      valReg   <= '0;
      timer    <= '0;
    end else begin
      if (cmd.latchCore) coreReg <= coreIn;
      if (cmd.latchCtrl) ctrlSave <= rdata;
      if (cmd.loadRead) valReg <= rdata;
      else if (cmd.loadWrite) valReg <= stepVal;
      if (cmd.timerClr) timer <= '0;
      else if (cmd.timerRun && (timer != '1)) timer <= timer + 1'b1;
    end
  end

endmodule

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
  import core_wake_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [SEL_W-1:0]  coreSel,
  input  logic              busAck,
  input  logic              busErr,
  input  logic              pollMet,
  input  logic              coreIsOn,
  input  logic              timedOut,
  output dpCtrl_t           cmd,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busRd,
  output logic              busWr,
  output logic              busy,
  output logic              donePulse,
  output logic              alreadyOn,
  output logic              errPulse
);

  localparam int MAX_CORE = 1;

  seqState_t state;
  logic      badSel;
  logic      ackOk;

  assign badSel = coreSel > SEL_W'(MAX_CORE);
  assign ackOk  = busAck && !busErr;
  assign busRd  = (state == ST_RD_CTRL) || (state == ST_RD_PWR) || (state == ST_POLL);
  assign busWr  = (state == ST_WR);
  assign busy   = (state != ST_IDLE);

  always_comb begin
    cmd           = '0;
    cmd.latchCore = (state == ST_IDLE) && startReq && !badSel;
    cmd.latchCtrl = (state == ST_RD_CTRL) && ackOk;
    cmd.loadRead  = ((state == ST_RD_PWR) || (state == ST_POLL)) && ackOk;
    cmd.loadWrite = (state == ST_WR) && ackOk;
    cmd.timerClr  = (state == ST_WR);
    cmd.timerRun  = (state == ST_POLL);
    cmd.selCtrl   = (state == ST_RD_CTRL) ||
                    ((state == ST_WR) && (stepIdx == STEP_W'(LAST_STEP)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepIdx   <= '0;
      donePulse <= 1'b0;
      alreadyOn <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      alreadyOn <= 1'b0;
      errPulse  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            if (badSel) errPulse <= 1'b1;
            else state <= ST_RD_CTRL;
          end
        end
        ST_RD_CTRL: begin
          if (busAck) begin
            if (busErr) begin
              errPulse <= 1'b1;
              state    <= ST_IDLE;
            end else if (coreIsOn) begin
              alreadyOn <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_RD_PWR;
            end
          end
        end
        ST_RD_PWR: begin
          if (busAck) begin
            if (busErr) begin
              errPulse <= 1'b1;
              state    <= ST_IDLE;
            end else begin
              stepIdx <= '0;
              state   <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (busAck) begin
            if (busErr) begin
              errPulse <= 1'b1;
              state    <= ST_IDLE;
            end else if (stepIdx == STEP_W'(LAST_STEP)) begin
              donePulse <= 1'b1;
              state     <= ST_IDLE;
            end else if (stepPolls(stepIdx)) begin
              state <= ST_POLL;
            end else begin
              stepIdx <= stepIdx + 1'b1;
            end
          end
        end
        ST_POLL: begin
          if (busAck) begin
            if (busErr) begin
              errPulse <= 1'b1;
              state    <= ST_IDLE;
            end else if (pollMet) begin
              stepIdx <= stepIdx + 1'b1;
              state   <= ST_WR;
            end else if (timedOut) begin
              errPulse <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import core_wake_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 2,
  parameter int TIMER_W     = 16,
  parameter int CTRL_OFFSET = 'h30,
  parameter int PWR_BASE    = 'h34,
  parameter int PWR_STRIDE  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [SEL_W-1:0]   coreSel,
  input  logic [TIMER_W-1:0] pollLimit,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [31:0]        busWdata,
  output logic               busRd,
  output logic               busWr,
  input  logic [31:0]        busRdata,
  input  logic               busAck,
  input  logic               busErr,
  output logic               busy,
  output logic               donePulse,
  output logic               alreadyOn,
  output logic               errPulse
);

  dpCtrl_t           cmd;
  logic [STEP_W-1:0] stepIdx;
  logic              pollMet;
  logic              coreIsOn;
  logic              timedOut;

  core_wake_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .coreSel   (coreSel),
    .busAck    (busAck),
    .busErr    (busErr),
    .pollMet   (pollMet),
    .coreIsOn  (coreIsOn),
    .timedOut  (timedOut),
    .cmd       (cmd),
    .stepIdx   (stepIdx),
    .busRd     (busRd),
    .busWr     (busWr),
    .busy      (busy),
    .donePulse (donePulse),
    .alreadyOn (alreadyOn),
    .errPulse  (errPulse)
  );

  core_wake_dp #(
    .ADDR_W      (ADDR_W),
    .TIMER_W     (TIMER_W),
    .CTRL_OFFSET (CTRL_OFFSET),
    .PWR_BASE    (PWR_BASE),
    .PWR_STRIDE  (PWR_STRIDE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .stepIdx   (stepIdx),
    .coreIn    (coreSel[0]),
    .rdata     (busRdata),
    .pollLimit (pollLimit),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .pollMet   (pollMet),
    .coreIsOn  (coreIsOn),
    .timedOut  (timedOut)
  );

endmodule

// File: rtl/core_wake_chk.sv
module core_wake_chk #(
  parameter int ADDR_W      = 8,
  parameter int SEL_W       = 2,
  parameter int CTRL_OFFSET = 'h30,
  parameter int PWR_BASE    = 'h34,
  parameter int PWR_STRIDE  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic [SEL_W-1:0]  coreSel,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busRd,
  input logic              busWr,
  input logic              busAck,
  input logic              busErr,
  input logic              busy,
  input logic              donePulse,
  input logic              alreadyOn,
  input logic              errPulse
);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((busRd || busWr) && !busAck) |=>
      (busRd == $past(busRd)) && (busWr == $past(busWr)) &&
      $stable(busAddr) && $stable(busWdata));

  p_addr_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |->
      (busAddr == ADDR_W'(CTRL_OFFSET)) || (busAddr == ADDR_W'(PWR_BASE)) ||
      (busAddr == ADDR_W'(PWR_BASE + PWR_STRIDE)));

  p_one_outcome_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({donePulse, alreadyOn, errPulse}));

  p_idle_at_end_r13: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse || alreadyOn || errPulse) |-> !busy);

  p_done_after_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(busWr && busAck && !busErr && (busAddr == ADDR_W'(CTRL_OFFSET))));

  p_on_from_ctrl_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    alreadyOn |-> $past(busRd && busAck && !busErr && (busAddr == ADDR_W'(CTRL_OFFSET))));

  p_bad_index_r12: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && (coreSel > SEL_W'(1))) |=> (errPulse && !busy && !busRd && !busWr));

  p_err_stops_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && busErr) |=> (!busRd && !busWr && errPulse));

endmodule

bind core_wake_seq core_wake_chk #(
  .ADDR_W      (ADDR_W),
  .SEL_W       (SEL_W),
  .CTRL_OFFSET (CTRL_OFFSET),
  .PWR_BASE    (PWR_BASE),
  .PWR_STRIDE  (PWR_STRIDE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .coreSel   (coreSel),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busRd     (busRd),
  .busWr     (busWr),
  .busAck    (busAck),
  .busErr    (busErr),
  .busy      (busy),
  .donePulse (donePulse),
  .alreadyOn (alreadyOn),
  .errPulse  (errPulse)
);

// File: tb/core_wake_seq_tb.sv
`timescale 1ns/1ps
module core_wake_seq_tb;

  localparam logic [7:0]  CTRL_A   = 8'h30;
  localparam logic [7:0]  PWR0_A   = 8'h34;
  localparam logic [7:0]  PWR1_A   = 8'h38;
  localparam logic [31:0] CMD_MASK = 32'h00FF_FFCF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [1:0]  coreSel = '0;
  logic [15:0] pollLimit = 16'd1000;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic        busRd, busWr;
  logic [31:0] busRdata;
  logic        busAck, busErr;
  logic        busy, donePulse, alreadyOn, errPulse;

  always #10 clk = ~clk;

  core_wake_seq u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .coreSel(coreSel), .pollLimit(pollLimit),
    .busAddr(busAddr), .busWdata(busWdata), .busRd(busRd), .busWr(busWr),
    .busRdata(busRdata), .busAck(busAck), .busErr(busErr), .busy(busy),
    .donePulse(donePulse), .alreadyOn(alreadyOn), .errPulse(errPulse)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // power block model
  logic [31:0] ctrlReg;
  logic [31:0] pwrStore [2];
  logic [31:0] pwrStat [2];
  int          readsSince [2];
  int          lag = 0;
  bit          stuck = 0;
  int          errAt = -1;
  int          latMax = 0;
  int          txnN = 0;
  int          waitCnt = 0;
  bit          logWr [256];
  logic [7:0]  logAddr [256];
  logic [31:0] logData [256];
  int          logN = 0;
  logic [31:0] rdTmp;
  bit          failTmp;
  int          kTmp;

  function automatic logic [31:0] statOf(input logic [31:0] v);
    logic [31:0] s = '0;
    s[29:28] = v[21:20];
    s[25:24] = v[17:16];
    s[5]     = v[1];
    s[4]     = v[0];
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      busAck   <= 1'b0;
      busErr   <= 1'b0;
      busRdata <= '0;
      waitCnt  = 0;
    end else if (busAck) begin
      busAck  <= 1'b0;
      busErr  <= 1'b0;
      waitCnt = (latMax == 0) ? 0 : int'($urandom % (latMax + 1));
    end else if (busRd || busWr) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        failTmp = (txnN == errAt);
        if (logN < 256) begin
          logWr[logN]   = busWr;
          logAddr[logN] = busAddr;
          logData[logN] = busWdata;
        end
        logN++;
        txnN++;
        rdTmp = 32'hDEAD_BEEF;
        if (busAddr == CTRL_A) begin
          if (busWr && !failTmp) ctrlReg = busWdata;
          rdTmp = ctrlReg;
        end else if (busAddr == PWR0_A || busAddr == PWR1_A) begin
          kTmp = (busAddr == PWR1_A) ? 1 : 0;
          if (busWr) begin
            if (!failTmp) begin
              pwrStore[kTmp]   = busWdata & CMD_MASK;
              readsSince[kTmp] = 0;
            end
          end else begin
            readsSince[kTmp]++;
            if (!stuck && readsSince[kTmp] > lag) pwrStat[kTmp] = statOf(pwrStore[kTmp]);
            rdTmp = pwrStore[kTmp] | pwrStat[kTmp];
          end
        end
        busRdata <= rdTmp;
        busErr   <= failTmp;
        busAck   <= 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R13 watchdog expired: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic setup(input logic [31:0] c0, input logic [31:0] p0, input logic [31:0] p1,
                       input int lg, input bit st, input int ea, input int lm,
                       input logic [15:0] lim);
    ctrlReg       = c0;
    pwrStore[0]   = p0 & CMD_MASK;
    pwrStore[1]   = p1 & CMD_MASK;
    pwrStat[0]    = statOf(pwrStore[0]);
    pwrStat[1]    = statOf(pwrStore[1]);
    readsSince[0] = 0;
    readsSince[1] = 0;
    lag = lg; stuck = st; errAt = ea; latMax = lm;
    pollLimit = lim;
    txnN = 0; logN = 0;
  endtask

  task automatic startSeq(input logic [1:0] c);
    @(negedge clk);
    coreSel  = c;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R13", "busy the cycle after start", 32'(busy), 32'd1);
  endtask

  // kind: 1 done, 2 already-on, 3 error, -1 none
  task automatic waitEnd(output int kind, output int cyc);
    kind = -1;
    cyc  = 0;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (donePulse || alreadyOn || errPulse) begin
        check($countones({donePulse, alreadyOn, errPulse}) == 1, "R13", "one outcome pulse",
              32'({donePulse, alreadyOn, errPulse}), 32'd0);
        kind = donePulse ? 1 : (alreadyOn ? 2 : 3);
        @(negedge clk);
        check(!donePulse && !alreadyOn && !errPulse && !busy, "R13", "pulse one cycle, idle after",
              32'({busy, donePulse, alreadyOn, errPulse}), 32'd0);
        return;
      end
    end
    check(1'b0, "R13", "request never ended", 32'(cyc), 32'd0);
  endtask

  function automatic string reqOf(input int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic verifyFull(input int c, input logic [31:0] c0, input logic [31:0] p0, input int lg);
    logic [31:0] v;
    logic [31:0] expW [8];
    logic [7:0]  pa;
    int w, reads;
    bit polls;
    pa = (c != 0) ? PWR1_A : PWR0_A;
    v = p0 & CMD_MASK;
    v = v | 32'h0030_0000; expW[0] = v;
    v = v | 32'h0003_0000; expW[1] = v;
    v = v & ~32'h0000_8000; expW[2] = v;
    v = v & ~32'h0000_0F00; expW[3] = v;
    v = v | 32'h2; expW[4] = v;
    v = v | 32'h1; expW[5] = v;
    v = v & ~32'h4; expW[6] = v;
    expW[7] = c0 | (32'h1 << (13 + c));
    check(logN >= 2 && !logWr[0] && logAddr[0] == CTRL_A, "R2", "first access reads control",
          32'(logAddr[0]), 32'(CTRL_A));
    check(!logWr[1] && logAddr[1] == pa, "R3", "second access reads core register",
          32'(logAddr[1]), 32'(pa));
    w = 0;
    reads = 0;
    for (int i = 2; i < logN && i < 256; i++) begin
      if (logWr[i]) begin
        if (w > 0) begin
          polls = (w - 1 == 0) || (w - 1 == 1) || (w - 1 == 4) || (w - 1 == 5);
          if (polls)
            check(reads >= 1 && reads <= lg + 1, reqOf(w - 1), "poll read count in range",
                  32'(reads), 32'(lg + 1));
          else
            check(reads == 0, reqOf(w - 1), "no read after plain write", 32'(reads), 32'd0);
        end
        if (w < 7) begin
          check(logAddr[i] == pa, "R1", "power write address", 32'(logAddr[i]), 32'(pa));
          check((logData[i] & CMD_MASK) == expW[w], reqOf(w), "power write value",
                logData[i] & CMD_MASK, expW[w]);
        end else if (w == 7) begin
          check(logAddr[i] == CTRL_A && logData[i] == expW[7], "R7", "reset release write",
                logData[i], expW[7]);
        end
        w++;
        reads = 0;
      end else begin
        reads++;
        check(logAddr[i] == pa, "R8", "poll reads same register", 32'(logAddr[i]), 32'(pa));
      end
    end
    check(w == 8, "R8", "one write per step", 32'(w), 32'd8);
    check(reads == 0, "R7", "nothing after final write", 32'(reads), 32'd0);
    check(ctrlReg == expW[7], "R7", "control word after release", ctrlReg, expW[7]);
  endtask

  task automatic countWrites(output int n);
    n = 0;
    for (int i = 0; i < logN && i < 256; i++) if (logWr[i]) n++;
  endtask

  initial begin
    int kind, cyc, nw, savedN;
    logic [31:0] c0, p0;
    void'($urandom(32'd20240607));

    // reset state
    repeat (3) @(negedge clk);
    check(!busy && !busRd && !busWr && !donePulse && !alreadyOn && !errPulse, "R13",
          "outputs low in reset", 32'({busy, busRd, busWr, donePulse, alreadyOn, errPulse}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !busRd && !busWr, "R9", "no request after reset",
          32'({busy, busRd, busWr}), 32'd0);

    // out-of-range index
    for (int s = 2; s < 4; s++) begin
      setup(32'h0, 32'h0, 32'h0, 0, 0, -1, 0, 16'd1000);
      @(negedge clk);
      coreSel  = 2'(s);
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      check(errPulse && !busy && !busRd && !busWr, "R12", "bad index rejected at once",
            32'({errPulse, busy, busRd, busWr}), 32'h8);
      @(negedge clk);
      check(!errPulse && !busy, "R12", "reject pulse one cycle", 32'({errPulse, busy}), 32'd0);
      repeat (4) @(negedge clk);
      check(logN == 0, "R12", "no traffic for bad index", 32'(logN), 32'd0);
    end

    // full wake-up, core 0, fastest responses
    c0 = 32'h0000_4001; p0 = 32'h0000_8F04;
    setup(c0, p0, 32'h0, 0, 0, -1, 0, 16'd1000);
    startSeq(2'd0);
    waitEnd(kind, cyc);
    check(kind == 1, "R7", "core0 done", 32'(kind), 32'd1);
    verifyFull(0, c0, p0, 0);

    // full wake-up, core 1, slow status and bus
    c0 = 32'h8000_2000; p0 = 32'h0000_0F05;
    setup(c0, 32'h0, p0, 3, 0, -1, 2, 16'd1000);
    startSeq(2'd1);
    waitEnd(kind, cyc);
    check(kind == 1, "R7", "core1 done", 32'(kind), 32'd1);
    verifyFull(1, c0, p0, 3);

    // already on: core 1 with its own bit set
    setup(32'h0000_4000, 32'h0, 32'h0, 0, 0, -1, 1, 16'd1000);
    startSeq(2'd1);
    waitEnd(kind, cyc);
    check(kind == 2, "R2", "core1 already on", 32'(kind), 32'd2);
    countWrites(nw);
    check(logN == 1 && nw == 0, "R2", "only the control read", 32'(logN), 32'd1);
    check(ctrlReg == 32'h0000_4000, "R2", "control word untouched", ctrlReg, 32'h0000_4000);

    // start while busy is ignored
    c0 = 32'h0; p0 = 32'h0;
    setup(c0, p0, 32'h0, 2, 0, -1, 2, 16'd1000);
    startSeq(2'd0);
    repeat (3) @(negedge clk);
    coreSel = 2'd1; startReq = 1'b1;
    @(negedge clk);
    coreSel = 2'd3;
    @(negedge clk);
    startReq = 1'b0; coreSel = 2'd0;
    waitEnd(kind, cyc);
    check(kind == 1, "R12", "first request completes", 32'(kind), 32'd1);
    verifyFull(0, c0, p0, 2);
    savedN = logN;
    repeat (10) @(negedge clk);
    check(logN == savedN && !busy && !errPulse, "R12", "ignored start left no work",
          32'(logN), 32'(savedN));

    // bus error on a poll read
    setup(32'h0, 32'h0, 32'h0, 0, 0, 3, 0, 16'd1000);
    startSeq(2'd0);
    waitEnd(kind, cyc);
    check(kind == 3, "R10", "error on poll read", 32'(kind), 32'd3);
    repeat (10) @(negedge clk);
    countWrites(nw);
    check(logN == 4 && nw == 1, "R10", "no traffic after error", 32'(logN), 32'd4);

    // bus error on the very first read
    setup(32'h0, 32'h0, 32'h0, 0, 0, 0, 1, 16'd1000);
    startSeq(2'd1);
    waitEnd(kind, cyc);
    check(kind == 3 && logN == 1, "R10", "error on control read", 32'(logN), 32'd1);

    // bus error on the reset release write (index 13 with lag 0, zero status)
    setup(32'h0000_0100, 32'h0, 32'h0, 0, 0, 13, 0, 16'd1000);
    startSeq(2'd0);
    waitEnd(kind, cyc);
    check(kind == 3, "R10", "error on release write", 32'(kind), 32'd3);
    check(logN == 14 && logWr[13] && logAddr[13] == CTRL_A, "R10", "failing write was the release",
          32'(logN), 32'd14);

    // timeout on a stuck status
    setup(32'h0, 32'h0, 32'h0, 0, 1, -1, 0, 16'd20);
    startSeq(2'd0);
    waitEnd(kind, cyc);
    check(kind == 3, "R11", "stuck status times out", 32'(kind), 32'd3);
    check(cyc >= 20, "R11", "timeout not before limit", 32'(cyc), 32'd20);
    countWrites(nw);
    check(nw == 1, "R11", "no write after timeout", 32'(nw), 32'd1);

    // zero limit but status matches on first read
    setup(32'h0, 32'h0, 32'h0, 0, 0, -1, 0, 16'd0);
    startSeq(2'd1);
    waitEnd(kind, cyc);
    check(kind == 1, "R11", "matching read proceeds at zero limit", 32'(kind), 32'd1);
    verifyFull(1, 32'h0, 32'h0, 0);

    // constrained random trials
    for (int t = 0; t < 24; t++) begin
      int c, lg, lm;
      bit on;
      c  = int'($urandom % 2);
      c0 = $urandom;
      on = ($urandom % 4) == 0;
      c0[13 + c] = on;
      p0 = $urandom;
      lg = int'($urandom % 4);
      lm = int'($urandom % 3);
      setup(c0, (c == 0) ? p0 : $urandom, (c == 1) ? p0 : $urandom, lg, 0, -1, lm, 16'd1000);
      startSeq(2'(c));
      waitEnd(kind, cyc);
      if (on) begin
        countWrites(nw);
        check(kind == 2 && nw == 0, "R2", "random already-on", 32'(kind), 32'd2);
        check(ctrlReg == c0, "R2", "random control unchanged", ctrlReg, c0);
      end else begin
        check(kind == 1, "R7", "random wake-up done", 32'(kind), 32'd1);
        verifyFull(c, c0, p0, lg);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule